// File: doc/BRIEF.md
# Prescaled Watchdog Timer

A register-mapped watchdog that counts a 16-bit value down at a rate set by two scaling stages in series. The first stage divides the system clock by a programmable 8-bit value plus one. The second stage divides that again by 16, 32, 64 or 128. When the count is at zero and the next scaled tick arrives, the timer expires. It reloads from a software-held reload register and keeps running. On expiry it can latch a level interrupt, start a fixed-length system reset pulse, or both.

Software keeps the system alive by writing the count register before expiry. Such a write loads the counter at once and restarts the scaling chain, so a full period is granted from that write. A pending interrupt is dropped by any write to the clear location. While a debug-acknowledge input is high and the control word's debug-mask bit is set, both outputs are held low. The internal state keeps evolving during that time, so the outputs reappear when the mask is lifted.

The bus is a single-cycle select/write strobe with a byte address and a combinational read. Writes are taken on the rising clock edge.

Top module: `wdt_timer`

## Requirements
- R1: After synchronous reset, the control word reads 0x0000_8039: timer running, reset output enabled, interrupt disabled, prescale 0x80 and divider select 3. The reload and count registers read 0x8000, and both outputs are low.
- R2: Registers sit at byte offsets 0x0 (control), 0x4 (reload) and 0x8 (live count). Each reads back the value written, limited to its implemented bits: mask 0x0001_FF3D for control, 16 bits for the others. Offset 0xC always reads 0.
- R3: The control fields are: bit 5 run, bit 2 interrupt enable, bit 0 reset enable, bits 4:3 divider select S, bits 15:8 prescale P and bit 16 debug mask. With the timer running, one tick takes (P+1)*(16<<S) clocks. After a count write of N, the expiry becomes visible (N+1) ticks after the write edge.
- R4: A write to the count register loads the counter on that edge and clears the scaling chain, even while the timer is stopped. This is the keep-alive.
- R5: On expiry the counter takes the reload value and keeps counting down from it.
- R6: With the run bit clear, the counter and both scaling stages hold their state. Time spent stopped does not count toward the next tick, and no expiry happens.
- R7: An expiry with interrupt enable set makes the interrupt pending. It stays pending until any write to offset 0xC. If an expiry and a clear write fall on the same edge, the interrupt stays pending.
- R8: An expiry with reset enable set drives the reset output high for exactly 128 clocks. A new expiry during the pulse restarts it.
- R9: While the debug-mask bit and the debug-acknowledge input are both high, the interrupt and reset outputs are forced low. They return as soon as either bit is low.
- R10: An expiry with an enable bit clear produces nothing on that output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write qualifier for the access |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| dbg_ack | input | 1 | Debug acknowledge from the processor |
| irq_o | output | 1 | Level interrupt on expiry |
| wdt_rst_o | output | 1 | System reset pulse on expiry |

## Verification
A wrong prescale or divider state shows at the ports as an expiry edge landing off the computed (N+1)*(P+1)*(16<<S) cycle. That error appears within one watchdog period, so the sweep over prescale, divider and start count measures the exact edge count. A counter that fails to reload or to freeze shows up at the next expiry, or at once as a live-count read after a stopped interval. A broken pulse counter shows in the measured high time of the reset output, and a lost pending flag shows the first cycle the interrupt drops without a clear write.

// File: rtl/wdt_pkg.sv
// Package: shared field positions, register offsets and the control type
// for the prescaled watchdog. Assumes a 32-bit register bus with byte offsets.
package wdt_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int PRE_W  = 8;
    localparam int SEL_W  = 2;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_RELOAD = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 4'hC;

    localparam int CB_RST_EN = 0;
    localparam int CB_IRQ_EN = 2;
    localparam int CB_DIV_LO = 3;
    localparam int CB_RUN    = 5;
    localparam int CB_PRE_LO = 8;
    localparam int CB_DBG    = 16;

    typedef struct packed {
        logic             dbg_mask;
        logic [PRE_W-1:0] prescale;
        logic             run;
        logic [SEL_W-1:0] div_sel;
        logic             irq_en;
        logic             rst_en;
    } wdt_ctrl_t;

    localparam wdt_ctrl_t CTRL_RESET = '{dbg_mask: 1'b0, prescale: 8'h80,
                                         run: 1'b1, div_sel: 2'd3,
                                         irq_en: 1'b0, rst_en: 1'b1};

    function automatic logic [DATA_W-1:0] ctrl_to_word(wdt_ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CB_RST_EN]             = c.rst_en;
        w[CB_IRQ_EN]             = c.irq_en;
        w[CB_DIV_LO +: SEL_W]    = c.div_sel;
        w[CB_RUN]                = c.run;
        w[CB_PRE_LO +: PRE_W]    = c.prescale;
        w[CB_DBG]                = c.dbg_mask;
        return w;
    endfunction

    function automatic wdt_ctrl_t word_to_ctrl(logic [DATA_W-1:0] w);
        wdt_ctrl_t c;
        c.rst_en   = w[CB_RST_EN];
        c.irq_en   = w[CB_IRQ_EN];
        c.div_sel  = w[CB_DIV_LO +: SEL_W];
        c.run      = w[CB_RUN];
        c.prescale = w[CB_PRE_LO +: PRE_W];
        c.dbg_mask = w[CB_DBG];
        return c;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
// Register decode: holds the control word and reload value, produces write
// strobes for the count and clear locations and muxes read data.
// Assumes single-cycle accesses; unmapped offsets read zero, writes ignored.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int               CNT_W      = 16,
    parameter logic [CNT_W-1:0] RESET_LOAD = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  live_count,
    output wdt_ctrl_t         ctrl_q,
    output logic [CNT_W-1:0]  reload_q,
    output logic              count_wr,
    output logic [CNT_W-1:0]  count_wval,
    output logic              clear_wr,
    output logic [DATA_W-1:0] bus_rdata
);

    logic wr_any;
    assign wr_any     = bus_sel & bus_we;
    assign count_wr   = wr_any & (bus_addr == OFS_COUNT);
    assign clear_wr   = wr_any & (bus_addr == OFS_CLEAR);
    assign count_wval = bus_wdata[CNT_W-1:0];

    // Control and reload storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= CTRL_RESET;
            reload_q <= RESET_LOAD;
        end else if (wr_any) begin
            if (bus_addr == OFS_CTRL)   ctrl_q   <= word_to_ctrl(bus_wdata);
            if (bus_addr == OFS_RELOAD) reload_q <= bus_wdata[CNT_W-1:0];
        end
    end

    // Read data mux; clear location and holes return zero
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                OFS_CTRL:   bus_rdata = ctrl_to_word(ctrl_q);
                OFS_RELOAD: bus_rdata = DATA_W'(reload_q);
                OFS_COUNT:  bus_rdata = DATA_W'(live_count);
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/wdt_tick.sv
// Two-stage clock scaler: an (P+1) prescaler followed by a 2^(4+S) divider.
// Emits a one-cycle tick per full period. Both stages freeze while run is
// low and clear on restart. Uses >= compares so a smaller P or S written
// mid-period ends the period instead of wrapping the stage.
module wdt_tick
    import wdt_pkg::*;
#(
    parameter int DIV_LOG0 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] prescale,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);

    localparam int DIV_W = DIV_LOG0 + (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_limit;
    logic             pre_wrap;
    logic             div_last;

    always_comb div_limit = DIV_W'((32'd1 << (DIV_LOG0 + int'(div_sel))) - 32'd1);

    assign pre_wrap = (pre_q >= prescale);
    assign div_last = (div_q >= div_limit);
    assign tick     = run & pre_wrap & div_last;

    // Advance prescaler every clock and divider on prescaler wrap
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pre_q <= '0;
            div_q <= '0;
        end else if (run) begin
            if (pre_wrap) begin
                pre_q <= '0;
                div_q <= div_last ? '0 : div_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdt_counter.sv
// Down-counter: a software write loads it, each tick decrements it, and a
// tick at zero is an expiry that reloads it. A write wins over a tick on
// the same edge and suppresses that expiry.
module wdt_counter #(
    parameter int               CNT_W       = 16,
    parameter logic [CNT_W-1:0] RESET_COUNT = 16'h8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count_q,
    output logic             expire
);

    logic at_zero;
    assign at_zero = (count_q == '0);
    assign expire  = tick & at_zero & ~load_wr;

    // Count state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= RESET_COUNT;
        end else if (load_wr) begin
            count_q <= load_val;
        end else if (tick) begin
            count_q <= at_zero ? reload : count_q - 1'b1;
        end
    end

endmodule

// File: rtl/wdt_events.sv
// Expiry consequences: a sticky interrupt flag and a fixed-length reset
// pulse, each gated by its enable at the expiry edge. Outputs are hidden
// while dbg_hide is high without disturbing the underlying state.
module wdt_events #(
    parameter int RST_CYCLES = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic irq_en,
    input  logic rst_en,
    input  logic clear_wr,
    input  logic dbg_hide,
    output logic irq_o,
    output logic rst_o,
    output logic rst_busy
);

    localparam int RC_W = $clog2(RST_CYCLES + 1);

    logic            pend_q;
    logic [RC_W-1:0] left_q;

    // Pending interrupt: set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)                 pend_q <= 1'b0;
        else if (expire && irq_en)  pend_q <= 1'b1;
        else if (clear_wr)          pend_q <= 1'b0;
    end

    // Reset pulse length counter, retriggerable
    always_ff @(posedge clk) begin
        if (!rst_n)                 left_q <= '0;
        else if (expire && rst_en)  left_q <= RC_W'(RST_CYCLES);
        else if (left_q != '0)      left_q <= left_q - 1'b1;
    end

    assign rst_busy = (left_q != '0);
    assign irq_o    = pend_q & ~dbg_hide;
    assign rst_o    = rst_busy & ~dbg_hide;

endmodule

// File: rtl/wdt_timer.sv
// Top of the prescaled watchdog: register decode, two-stage scaler,
// down-counter and expiry outputs. Synchronous active-low reset.
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int               CNT_W      = 16,
    parameter int               RST_CYCLES = 128,
    parameter int               DIV_LOG0   = 4,
    parameter logic [CNT_W-1:0] RESET_LOAD = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dbg_ack,
    output logic              irq_o,
    output logic              wdt_rst_o
);

    wdt_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_wval;
    logic             count_wr;
    logic             clear_wr;
    logic             tick;
    logic             expire;
    logic             dbg_hide;
    logic             rst_busy;

    assign dbg_hide = ctrl_q.dbg_mask & dbg_ack;

    wdt_regs #(.CNT_W(CNT_W), .RESET_LOAD(RESET_LOAD)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .live_count(count_q),
        .ctrl_q(ctrl_q), .reload_q(reload_q), .count_wr(count_wr),
        .count_wval(count_wval), .clear_wr(clear_wr), .bus_rdata(bus_rdata)
    );

    wdt_tick #(.DIV_LOG0(DIV_LOG0)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .restart(count_wr),
        .prescale(ctrl_q.prescale), .div_sel(ctrl_q.div_sel), .tick(tick)
    );

    wdt_counter #(.CNT_W(CNT_W), .RESET_COUNT(RESET_LOAD)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load_wr(count_wr),
        .load_val(count_wval), .reload(reload_q), .count_q(count_q),
        .expire(expire)
    );

    wdt_events #(.RST_CYCLES(RST_CYCLES)) u_evt (
        .clk(clk), .rst_n(rst_n), .expire(expire), .irq_en(ctrl_q.irq_en),
        .rst_en(ctrl_q.rst_en), .clear_wr(clear_wr), .dbg_hide(dbg_hide),
        .irq_o(irq_o), .rst_o(wdt_rst_o), .rst_busy(rst_busy)
    );

endmodule

// File: rtl/wdt_timer_chk.sv
// Checker for the watchdog: temporal properties over ports and internal
// state, attached to every wdt_timer instance by the bind below.
module wdt_timer_chk
    import wdt_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int RST_CYCLES = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              dbg_ack,
    input logic              irq_o,
    input logic              ctrl_run,
    input logic              ctrl_irq_en,
    input logic              ctrl_rst_en,
    input logic              ctrl_dbg_mask,
    input logic [CNT_W-1:0]  count_q,
    input logic [CNT_W-1:0]  reload_q,
    input logic              expire,
    input logic              rst_busy
);

    localparam int LEN_W = $clog2(RST_CYCLES + 2) + 1;

    logic             cnt_wr;
    logic             clr_wr;
    logic [LEN_W-1:0] busy_len;

    assign cnt_wr = bus_sel & bus_we & (bus_addr == OFS_COUNT);
    assign clr_wr = bus_sel & bus_we & (bus_addr == OFS_CLEAR);

    // Length of the current reset pulse, restarted by each arming expiry
    always_ff @(posedge clk) begin
        if (!rst_n)                      busy_len <= '0;
        else if (expire && ctrl_rst_en)  busy_len <= '0;
        else if (rst_busy)               busy_len <= busy_len + 1'b1;
        else                             busy_len <= '0;
    end

    AST_LOAD_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> count_q == $past(bus_wdata[CNT_W-1:0])); // R4

    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> count_q == $past(reload_q)); // R5

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_run && !cnt_wr) |=> $stable(count_q)); // R6

    AST_NO_EXPIRE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_run |-> !expire); // R6

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> ($past(clr_wr) || (ctrl_dbg_mask && dbg_ack))); // R7

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (($past(expire) && $past(ctrl_irq_en)) || $past(ctrl_dbg_mask && dbg_ack))); // R10

    AST_RST_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        rst_busy |-> busy_len < LEN_W'(RST_CYCLES)); // R8

    AST_RST_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_busy) |-> $past(busy_len) == LEN_W'(RST_CYCLES - 1)); // R8

endmodule

bind wdt_timer wdt_timer_chk #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .dbg_ack(dbg_ack),
    .irq_o(irq_o), .ctrl_run(ctrl_q.run), .ctrl_irq_en(ctrl_q.irq_en),
    .ctrl_rst_en(ctrl_q.rst_en), .ctrl_dbg_mask(ctrl_q.dbg_mask),
    .count_q(count_q), .reload_q(reload_q), .expire(expire),
    .rst_busy(rst_busy)
);

// File: tb/wdt_timer_test.sv
`timescale 1ns/1ps
module wdt_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dbg_ack = 1'b0;
    logic        irq_o;
    logic        wdt_rst_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdt_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dbg_ack(dbg_ack), .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Write: driven at a falling edge, taken on the next rising edge,
    // released at the falling edge after it.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // Counts rising edges after the last write until irq_o is seen high
    task automatic wait_irq(input int limit, output int k);
        k = 0;
        while (k < limit) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            if (irq_o) break;
        end
    endtask

    function automatic logic [31:0] mk(bit run, bit ie, bit re, int sel, int pre, bit dbg);
        return (32'(dbg) << 16) | (32'(pre) << 8) | (32'(run) << 5) |
               (32'(sel) << 3) | (32'(ie) << 2) | 32'(re);
    endfunction

    initial begin
        logic [31:0] v;
        int k, w, exp;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'h0, v); check(v == 32'h0000_8039, "R1 ctrl", v, 32'h8039);
        rd(4'h4, v); check(v == 32'h8000, "R1 reload", v, 32'h8000);
        rd(4'h8, v); check(v == 32'h8000, "R1 count", v, 32'h8000);
        check(!irq_o && !wdt_rst_o, "R1 outputs", {30'd0, irq_o, wdt_rst_o}, 0);

        // R2 readback and masking
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, v); check(v == 32'hFFFF, "R2 reload", v, 32'hFFFF);
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, v); check(v == 32'h0001_FF3D, "R2 ctrl mask", v, 32'h1FF3D);
        wr(4'h0, mk(0, 0, 0, 0, 0, 0));
        rd(4'hC, v); check(v == 0, "R2 clear reads zero", v, 0);

        // R3 sweep of prescale, divider and start count
        for (int p = 0; p < 3; p++) begin
            for (int s = 0; s < 4; s++) begin
                for (int ni = 0; ni < 3; ni++) begin
                    int n;
                    n = (ni == 2) ? 3 : ni;
                    exp = (n + 1) * (p + 1) * (16 << s);
                    wr(4'hC, 0);
                    wr(4'h0, mk(1, 1, 0, s, p, 0));
                    wr(4'h8, n);
                    wait_irq(exp + 20, k);
                    check(k == exp, "R3 expiry period", k, exp);
                end
            end
        end

        // R7 sticky interrupt and clear
        repeat (50) @(negedge clk);
        check(irq_o == 1'b1, "R7 sticky", irq_o, 1);
        wr(4'hC, 32'h0);
        check(irq_o == 1'b0, "R7 clear", irq_o, 0);

        // R8 pulse width, R5 reload after expiry, R10 no irq
        wr(4'h4, 15);
        wr(4'h0, mk(1, 0, 1, 0, 0, 0));
        wr(4'h8, 0);
        k = 0;
        while (k < 100 && !wdt_rst_o) begin @(posedge clk); k++; @(negedge clk); end
        check(k == 16, "R8 pulse start", k, 16);
        w = 0;
        while (w < 300 && wdt_rst_o) begin w++; @(posedge clk); k++; @(negedge clk); end
        check(w == 128, "R8 pulse width", w, 128);
        while (k < 600 && !wdt_rst_o) begin @(posedge clk); k++; @(negedge clk); end
        check(k == 272, "R5 reload period", k, 272);
        check(irq_o == 1'b0, "R10 irq off", irq_o, 0);

        // R10 both enables off, R5 count reloaded
        wr(4'h0, mk(0, 0, 0, 0, 0, 0));
        repeat (200) @(negedge clk);
        wr(4'h4, 32'h100);
        wr(4'h0, mk(1, 0, 0, 0, 0, 0));
        wr(4'h8, 0);
        repeat (20) @(negedge clk);
        check(!irq_o && !wdt_rst_o, "R10 silent expiry", {30'd0, irq_o, wdt_rst_o}, 0);
        rd(4'h8, v); check(v == 32'h100, "R5 reloaded count", v, 32'h100);

        // R6 freeze while stopped; R4 load while stopped
        wr(4'h4, 32'hFFFF);
        wr(4'h0, mk(0, 1, 0, 0, 0, 0));
        wr(4'h8, 3);
        repeat (300) @(negedge clk);
        rd(4'h8, v); check(v == 3, "R6 count frozen", v, 3);
        check(irq_o == 1'b0, "R6 no expiry", irq_o, 0);
        wr(4'h0, mk(1, 1, 0, 0, 0, 0));
        wait_irq(200, k);
        check(k == 64, "R6 resume timing", k, 64);
        wr(4'hC, 0);
        wr(4'h8, 0);
        wr(4'h0, mk(0, 1, 0, 0, 0, 0));
        repeat (50) @(negedge clk);
        check(irq_o == 1'b0, "R6 stopped mid-period", irq_o, 0);
        wr(4'h0, mk(1, 1, 0, 0, 0, 0));
        wait_irq(100, k);
        check(k == 14, "R6 scaler state kept", k, 14);

        // R4 keep-alive restarts the period
        wr(4'hC, 0);
        wr(4'h8, 2);
        repeat (40) @(negedge clk);
        check(irq_o == 1'b0, "R4 before kick", irq_o, 0);
        wr(4'h8, 2);
        wait_irq(100, k);
        check(k == 48, "R4 after kick", k, 48);

        // R9 debug masking
        wr(4'hC, 0);
        dbg_ack = 1'b1;
        wr(4'h0, mk(1, 1, 1, 0, 0, 1));
        wr(4'h8, 0);
        repeat (20) @(negedge clk);
        check(!irq_o && !wdt_rst_o, "R9 hidden", {30'd0, irq_o, wdt_rst_o}, 0);
        dbg_ack = 1'b0;
        #1 check(irq_o && wdt_rst_o, "R9 released", {30'd0, irq_o, wdt_rst_o}, 3);
        dbg_ack = 1'b1;
        wr(4'h0, mk(1, 1, 1, 0, 0, 0));
        check(irq_o && wdt_rst_o, "R9 mask bit off", {30'd0, irq_o, wdt_rst_o}, 3);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog timeout actual=0x0 expected=0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule